// File: doc/BRIEF.md
# Wake-up Frame Detector

This block watches the receive byte stream of an Ethernet port while the device sleeps. It looks for a wake-up frame and raises a sticky flag when it finds one. The frame must pass the destination-address filter. Its payload must hold a run of 0xFF synchronization bytes, and right after that run, sixteen back-to-back copies of the 48-bit station address. The caller checks the frame check sequence and reports the result with a frame-good bit on the last byte. The caller also handles waking the host and any power sequencing.

Detection runs only in wake mode. Wake mode can be entered by software through an enable bit. It can also be entered through a pin-armed path, which takes effect when the power-good input drops. Two separate relax bits widen the address filter so that any destination address is accepted. The payload rule stays the same either way. Outside wake mode the scanner is held idle and frames are ignored.

Top module: `wake_frame_detector`

## Requirements
- R1: `wake_mode` is high exactly when `cfg_sw_en` is 1, or when `cfg_pin_en` is 1 and `pwr_good` is 0.
- R2: With both relax inputs at 0, frame bytes 0 to 5 (the destination address) must equal `station_addr[47:40]`, `[39:32]`, `[31:24]`, `[23:16]`, `[15:8]`, `[7:0]` in that order. Any difference blocks a match.
- R3: With `cfg_relax_a` or `cfg_relax_b` at 1, any destination address is accepted. The payload rule of R4 still applies.
- R4: From byte 6 on, a match needs at least six consecutive 0xFF bytes. Directly after them must come sixteen consecutive copies of the station address, each sent high byte first as in R2. Fifteen copies are not enough.
- R5: A byte that breaks the copy sequence restarts the search at that byte. If that byte is 0xFF, it counts as the first byte of a new synchronization run.
- R6: The flag can only be set on the byte marked with `rx_eof`, and only when `rx_frame_ok` is 1 on that byte.
- R7: `match_flag` rises on the clock edge that takes the qualifying end-of-frame byte. It then stays 1 whatever frames follow, until `rst_n` is low.
- R8: Outside wake mode, bytes are ignored and scanner state is cleared. A frame whose start byte arrived outside wake mode cannot match, even if wake mode is entered before it ends.
- R9: While `rst_n` is low on a clock edge, `match_flag` is cleared to 0.
- R10: A synchronization run longer than six 0xFF bytes is still accepted, as long as the copies follow it directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on reset) |
| station_addr | input | 48 | Station address, bits 47:40 sent first |
| cfg_pin_en | input | 1 | Arms wake-mode entry on a low `pwr_good` |
| cfg_sw_en | input | 1 | Software wake-mode entry |
| cfg_relax_a | input | 1 | Address relax bit A |
| cfg_relax_b | input | 1 | Address relax bit B |
| pwr_good | input | 1 | Power-good indication |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_frame_ok | input | 1 | Frame passed its check sequence; read on the end byte |
| wake_mode | output | 1 | Detector is in wake mode (combinational) |
| match_flag | output | 1 | Sticky wake-up frame detected |

## Verification
`wake_mode` is combinational, so the bench reads it at the falling edge right after it changes the configuration inputs. `match_flag` changes on the rising edge that takes the end-of-frame byte. The bench drives each byte at a falling edge and drops `rx_valid` at the next one, then reads the flag there, half a cycle after the deciding edge. Stickiness and reset clearing are checked at falling edges, after further frames and after reset cycles.

// File: rtl/wfd_pkg.sv
// Package: shared constants and byte selection for the wake-up frame detector.
// Assumes the station address is sent most significant byte first.
package wfd_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = 8 * ADDR_BYTES;
    localparam int SYNC_LEN   = 6;
    localparam int COPIES     = 16;
    localparam logic [7:0] SYNC_BYTE = 8'hFF;

    // Returns byte k of the address in line order (k = 0 is the top byte).
    function automatic logic [7:0] pick_byte(input logic [ADDR_W-1:0] a, input int k);
        logic [7:0] r;
        r = '0;
        for (int j = 0; j < ADDR_BYTES; j++) begin
            if (j == k) r = a[ADDR_W-8-8*j +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/wfd_mode_ctl.sv
// Wake-mode decision: the software enable, or the pin-armed path with power-good low.
// Assumes pwr_good is already synchronous to clk.
module wfd_mode_ctl (
    input  logic cfg_pin_en,
    input  logic cfg_sw_en,
    input  logic pwr_good,
    output logic wake_mode
);
    // Combine the two entry paths.
    always_comb wake_mode = cfg_sw_en | (cfg_pin_en & ~pwr_good);
endmodule

// File: rtl/wfd_addr_filter.sv
// Destination-address filter: tracks the byte index in the frame and compares
// the leading address bytes with the station address.
// Assumes take is high only for bytes of a frame accepted in wake mode.
module wfd_addr_filter
    import wfd_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES,
    localparam int IW = $clog2(N_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic                 sof,
    input  logic [7:0]           data,
    input  logic [8*N_BYTES-1:0] station_addr,
    output logic                 in_payload,
    output logic                 da_ok
);
    logic [IW-1:0] idx_q;
    logic [IW-1:0] cur_idx;
    logic          is_da;
    logic          byte_eq;

    // Index of the current byte and whether it lies in the address field.
    always_comb begin
        cur_idx    = sof ? '0 : idx_q;
        is_da      = cur_idx < IW'(N_BYTES);
        in_payload = !is_da;
        byte_eq    = data == pick_byte(station_addr, int'(cur_idx));
    end

    // Saturating byte index within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx_q <= '0;
        else if (take)  idx_q <= is_da ? cur_idx + IW'(1) : cur_idx;
    end

    // Running equality over the address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)              da_ok <= 1'b0;
        else if (take && sof)    da_ok <= byte_eq;
        else if (take && is_da)  da_ok <= da_ok & byte_eq;
    end
endmodule

// File: rtl/wfd_pattern_scan.sv
// Payload scanner: finds a run of sync bytes followed directly by the required
// number of back-to-back station address copies. A broken sequence restarts
// the search at the breaking byte.
// Assumes en is high only for payload bytes; clear wipes all progress.
module wfd_pattern_scan
    import wfd_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES,
    parameter int N_SYNC  = SYNC_LEN,
    parameter int N_COPY  = COPIES,
    localparam int FW = $clog2(N_SYNC + 1),
    localparam int BW = $clog2(N_BYTES),
    localparam int CW = (N_COPY > 1) ? $clog2(N_COPY) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 en,
    input  logic [7:0]           data,
    input  logic [8*N_BYTES-1:0] station_addr,
    output logic                 found_d
);
    logic [FW-1:0] ff_q, ff_d;
    logic [BW-1:0] bi_q, bi_d;
    logic [CW-1:0] cp_q, cp_d;
    logic          found_q;
    logic [7:0]    exp_byte;
    logic          is_sync;

    // Next-state logic for the sync run and copy position.
    always_comb begin
        ff_d     = ff_q;
        bi_d     = bi_q;
        cp_d     = cp_q;
        found_d  = found_q;
        exp_byte = pick_byte(station_addr, int'(bi_q));
        is_sync  = data == SYNC_BYTE;
        if (clear) begin
            ff_d    = '0;
            bi_d    = '0;
            cp_d    = '0;
            found_d = 1'b0;
        end else if (en && !found_q) begin
            if (ff_q == FW'(N_SYNC)) begin
                if (data == exp_byte) begin
                    if (bi_q == BW'(N_BYTES - 1)) begin
                        bi_d = '0;
                        if (cp_q == CW'(N_COPY - 1)) found_d = 1'b1;
                        else                         cp_d = cp_q + CW'(1);
                    end else begin
                        bi_d = bi_q + BW'(1);
                    end
                end else if (!(cp_q == '0 && bi_q == '0 && is_sync)) begin
                    ff_d = is_sync ? FW'(1) : '0;
                    bi_d = '0;
                    cp_d = '0;
                end
            end else begin
                ff_d = is_sync ? ff_q + FW'(1) : '0;
            end
        end
    end

    // Scanner state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_q    <= '0;
            bi_q    <= '0;
            cp_q    <= '0;
            found_q <= 1'b0;
        end else begin
            ff_q    <= ff_d;
            bi_q    <= bi_d;
            cp_q    <= cp_d;
            found_q <= found_d;
        end
    end
endmodule

// File: rtl/wake_frame_detector.sv
// Wake-up frame detector top: gates the receive stream by wake mode, tracks
// frame boundaries, and sets a sticky flag on a qualifying good frame.
// Assumes rx_sof and rx_eof come with rx_valid, and rx_frame_ok is meaningful
// on the end byte.
module wake_frame_detector
    import wfd_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES,
    parameter int N_SYNC  = SYNC_LEN,
    parameter int N_COPY  = COPIES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [8*N_BYTES-1:0] station_addr,
    input  logic                 cfg_pin_en,
    input  logic                 cfg_sw_en,
    input  logic                 cfg_relax_a,
    input  logic                 cfg_relax_b,
    input  logic                 pwr_good,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_data,
    input  logic                 rx_sof,
    input  logic                 rx_eof,
    input  logic                 rx_frame_ok,
    output logic                 wake_mode,
    output logic                 match_flag
);
    logic active_q;
    logic take;
    logic in_payload;
    logic da_ok;
    logic found_d;
    logic hit;

    wfd_mode_ctl u_mode (
        .cfg_pin_en (cfg_pin_en),
        .cfg_sw_en  (cfg_sw_en),
        .pwr_good   (pwr_good),
        .wake_mode  (wake_mode)
    );

    // Accept a byte only in wake mode and inside a frame started in wake mode.
    always_comb take = wake_mode && rx_valid && (rx_sof || active_q);

    // Frame-in-progress tracking, dropped whenever wake mode is left.
    always_ff @(posedge clk) begin
        if (!rst_n || !wake_mode)   active_q <= 1'b0;
        else if (rx_valid && rx_eof) active_q <= 1'b0;
        else if (rx_valid && rx_sof) active_q <= 1'b1;
    end

    wfd_addr_filter #(.N_BYTES(N_BYTES)) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .sof          (rx_sof),
        .data         (rx_data),
        .station_addr (station_addr),
        .in_payload   (in_payload),
        .da_ok        (da_ok)
    );

    wfd_pattern_scan #(.N_BYTES(N_BYTES), .N_SYNC(N_SYNC), .N_COPY(N_COPY)) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (!wake_mode || (rx_valid && rx_sof)),
        .en           (take && in_payload),
        .data         (rx_data),
        .station_addr (station_addr),
        .found_d      (found_d)
    );

    // Qualifying end of frame: good frame, address passes, pattern seen.
    always_comb hit = take && rx_eof && rx_frame_ok && found_d
                      && (cfg_relax_a || cfg_relax_b || da_ok);

    // Sticky match flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   match_flag <= 1'b0;
        else if (hit) match_flag <= 1'b1;
    end
endmodule

// File: rtl/wfd_checker.sv
// Assertion checker for the wake-up frame detector, bound to the top module.
module wfd_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_pin_en,
    input logic cfg_sw_en,
    input logic pwr_good,
    input logic rx_valid,
    input logic rx_eof,
    input logic rx_frame_ok,
    input logic wake_mode,
    input logic match_flag
);
    p_sw_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sw_en |-> wake_mode);

    p_pin_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pin_en && !pwr_good) |-> wake_mode);

    p_no_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sw_en && !cfg_pin_en) |-> !wake_mode);

    p_rise_on_good_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> $past(rx_valid && rx_eof && rx_frame_ok));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_flag |=> match_flag);

    p_rise_in_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> $past(wake_mode));
endmodule

bind wake_frame_detector wfd_checker u_wfd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_pin_en  (cfg_pin_en),
    .cfg_sw_en   (cfg_sw_en),
    .pwr_good    (pwr_good),
    .rx_valid    (rx_valid),
    .rx_eof      (rx_eof),
    .rx_frame_ok (rx_frame_ok),
    .wake_mode   (wake_mode),
    .match_flag  (match_flag)
);

// File: tb/wake_frame_detector_bench.sv
module wake_frame_detector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXLEN     = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] station_addr = 48'h02_1A_3C_55_7E_90;
    logic        cfg_pin_en = 1'b0, cfg_sw_en = 1'b0;
    logic        cfg_relax_a = 1'b0, cfg_relax_b = 1'b0;
    logic        pwr_good = 1'b1;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_frame_ok = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        wake_mode, match_flag;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    logic [7:0] fb [MAXLEN];
    int flen;

    wake_frame_detector u_wake_frame_detector (
        .clk(clk), .rst_n(rst_n), .station_addr(station_addr),
        .cfg_pin_en(cfg_pin_en), .cfg_sw_en(cfg_sw_en),
        .cfg_relax_a(cfg_relax_a), .cfg_relax_b(cfg_relax_b),
        .pwr_good(pwr_good), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_frame_ok(rx_frame_ok),
        .wake_mode(wake_mode), .match_flag(match_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sbyte(input int k);
        return station_addr[40-8*k +: 8];
    endfunction

    // Expected result from the requirements (R2..R5, R10).
    function automatic bit ref_hit(input int n, input bit relax);
        bit da = 1'b1;
        int ff = 0, bi = 0, cp = 0;
        bit found = 1'b0;
        for (int i = 0; i < 6 && i < n; i++) if (fb[i] != sbyte(i)) da = 1'b0;
        for (int i = 6; i < n; i++) begin
            if (found) break;
            if (ff == 6) begin
                if (fb[i] == sbyte(bi)) begin
                    if (bi == 5) begin
                        bi = 0;
                        if (cp == 15) found = 1'b1; else cp++;
                    end else bi++;
                end else if (!(cp == 0 && bi == 0 && fb[i] == 8'hFF)) begin
                    ff = (fb[i] == 8'hFF) ? 1 : 0; bi = 0; cp = 0;
                end
            end else ff = (fb[i] == 8'hFF) ? ff + 1 : 0;
        end
        return found && (da || relax);
    endfunction

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 flag cleared in reset", int'(match_flag), 0);
        rst_n = 1'b1;
    endtask

    // Send fb[0..n-1]; sw_on_at >= 0 raises cfg_sw_en before that byte.
    task automatic send(input int n, input bit ok, input int sw_on_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == sw_on_at) cfg_sw_en = 1'b1;
            rx_valid = 1'b1; rx_data = fb[i];
            rx_sof = (i == 0); rx_eof = (i == n - 1);
            rx_frame_ok = (i == n - 1) ? ok : 1'b0;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_frame_ok = 1'b0;
    endtask

    // DA = station, pre filler bytes, ffs sync bytes, cps copies, post filler.
    task automatic build(input int pre, input int ffs, input int cps, input int post);
        int p = 0;
        for (int k = 0; k < 6; k++) fb[p++] = sbyte(k);
        for (int k = 0; k < pre; k++) fb[p++] = 8'($urandom % 255);
        for (int k = 0; k < ffs; k++) fb[p++] = 8'hFF;
        for (int c = 0; c < cps; c++) for (int k = 0; k < 6; k++) fb[p++] = sbyte(k);
        for (int k = 0; k < post; k++) fb[p++] = 8'h22;
        flen = p;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        do_reset();

        // R1: all eight combinations of the entry inputs.
        for (int m = 0; m < 8; m++) begin
            @(negedge clk);
            cfg_pin_en = m[0]; cfg_sw_en = m[1]; pwr_good = m[2];
            #1 chk("R1 wake_mode", int'(wake_mode), int'(m[1] | (m[0] & ~m[2])));
        end
        cfg_pin_en = 1'b0; cfg_sw_en = 1'b1; pwr_good = 1'b1;

        // R2/R4: exact address and full pattern.
        do_reset(); build(4, 6, 16, 3); send(flen, 1'b1, -1);
        chk("R4 full pattern match", int'(match_flag), 1);

        // R2: one destination byte off.
        do_reset(); build(4, 6, 16, 3); fb[3] ^= 8'h01; send(flen, 1'b1, -1);
        chk("R2 address mismatch blocks", int'(match_flag), 0);

        // R3: relax bits accept other and broadcast addresses.
        do_reset(); cfg_relax_a = 1'b1; send(flen, 1'b1, -1);
        chk("R3 relax_a accepts", int'(match_flag), 1);
        cfg_relax_a = 1'b0; cfg_relax_b = 1'b1;
        do_reset(); for (int k = 0; k < 6; k++) fb[k] = 8'hFF; send(flen, 1'b1, -1);
        chk("R3 relax_b broadcast", int'(match_flag), 1);
        do_reset(); build(4, 6, 15, 3); send(flen, 1'b1, -1);
        chk("R3 relax still needs pattern", int'(match_flag), 0);
        cfg_relax_b = 1'b0;

        // R4: fifteen copies only.
        do_reset(); build(2, 6, 15, 8); send(flen, 1'b1, -1);
        chk("R4 fifteen copies", int'(match_flag), 0);

        // R5: the breaking 0xFF starts a new sync run.
        do_reset(); build(2, 6, 0, 0);
        for (int k = 0; k < 3; k++) fb[flen++] = sbyte(k);
        for (int k = 0; k < 6; k++) fb[flen++] = 8'hFF;
        for (int c = 0; c < 16; c++) for (int k = 0; k < 6; k++) fb[flen++] = sbyte(k);
        send(flen, 1'b1, -1);
        chk("R5 resync on breaking byte", int'(match_flag), 1);
        do_reset(); build(2, 6, 16, 2); fb[6 + 2 + 6 + 40] = 8'h00; send(flen, 1'b1, -1);
        chk("R5 break without resync", int'(match_flag), 0);

        // R6: bad check sequence.
        do_reset(); build(1, 6, 16, 1); send(flen, 1'b0, -1);
        chk("R6 frame_ok low", int'(match_flag), 0);

        // R7: sticky across a later bad frame, cleared by reset.
        do_reset(); build(1, 6, 16, 1); send(flen, 1'b1, -1);
        chk("R7 set after good eof", int'(match_flag), 1);
        fb[2] = 8'h00; send(flen, 1'b0, -1);
        chk("R7 sticky after later frame", int'(match_flag), 1);
        do_reset();

        // R8: outside wake mode, and wake entered mid-frame.
        cfg_sw_en = 1'b0; build(1, 6, 16, 1); send(flen, 1'b1, -1);
        chk("R8 ignored outside wake", int'(match_flag), 0);
        send(flen, 1'b1, 20);
        chk("R8 mid-frame entry ignored", int'(match_flag), 0);
        cfg_sw_en = 1'b0; cfg_pin_en = 1'b1; pwr_good = 1'b0;
        do_reset(); send(flen, 1'b1, -1);
        chk("R1 pin path detects", int'(match_flag), 1);
        cfg_pin_en = 1'b0; pwr_good = 1'b1; cfg_sw_en = 1'b1;

        // R10: long sync run.
        do_reset(); build(3, 11, 16, 2); send(flen, 1'b1, -1);
        chk("R10 long sync run", int'(match_flag), 1);

        // Random frames checked against ref_hit.
        for (int it = 0; it < 60; it++) begin
            bit relax, ok, exp;
            int off;
            relax = ($urandom % 4) == 0;
            cfg_relax_a = relax & ($urandom % 2 == 0);
            cfg_relax_b = relax & !cfg_relax_a;
            ok = ($urandom % 4) != 0;
            flen = 110 + int'($urandom % 120);
            for (int k = 0; k < 6; k++) fb[k] = sbyte(k);
            if ($urandom % 4 == 0) fb[$urandom % 6] ^= 8'h10;
            for (int k = 6; k < flen; k++)
                fb[k] = ($urandom % 8 == 0) ? 8'hFF : 8'($urandom);
            if ($urandom % 5 < 3) begin
                off = 6 + int'($urandom % (flen - 6 - 102 + 1));
                for (int k = 0; k < 6; k++) fb[off + k] = 8'hFF;
                for (int k = 0; k < 96; k++) fb[off + 6 + k] = sbyte(k % 6);
                if ($urandom % 3 == 0) fb[off + 6 + int'($urandom % 96)] ^= 8'h04;
            end
            exp = ref_hit(flen, relax) && ok;
            do_reset(); send(flen, ok, -1);
            chk("R4 random frame", int'(match_flag), int'(exp));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule